// File: doc/BRIEF.md
# Per-Set Relative-Age Replacement Tracker

This block keeps the replacement order for a set-associative cache. Every line of every set carries a small relative age: zero marks the most recently touched line and the largest value marks the line touched longest ago. The cache controller reports each lookup outcome to the tracker: a hit on a line, a fill of an empty line, or a replacement of an occupied line. The tracker then updates the ages of that one set in a single clock edge.

For any set the controller names on the probe index, the tracker reports which way to use next. If the set still has an empty line, the answer is the lowest-numbered empty way. If the set is full, the answer is the way with the greatest age. The probed set's valid bits and ages are also brought out so that the controller can see the order. Tags and line data are held elsewhere.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset every line of every set is invalid with age 0, so for every probed set `free_avail` is 1 and `victim_way` is 0.
- R2: A fill (`acc_kind` = 2'b10) marks the addressed way valid with age 0 and raises by one the age of every other valid line of that set; invalid lines keep their age.
- R3: A hit (`acc_kind` = 2'b01) on a line of age X sets that line's age to 0 and raises by one only the valid lines of that set whose age is below X; lines at or above X keep their age, so a hit on an age-0 line changes nothing.
- R4: The valid lines of a set always hold pairwise distinct ages, none above NUM_WAYS-1.
- R5: When every line of the probed set is valid, `free_avail` is 0 and `victim_way` is the way whose age is NUM_WAYS-1.
- R6: When the probed set has at least one invalid line, `free_avail` is 1 and `victim_way` is the lowest-numbered invalid way.
- R7: A replacement (`acc_kind` = 2'b11) sets the addressed way's age to 0 and applies the hit rule to the others; replacing the oldest line therefore ages every other line by one.
- R8: An access updates only the set named by `acc_set`, and its result is visible on the probe outputs in the cycle after the clock edge that samples it.
- R9: `acc_kind` = 2'b00 is idle and leaves every age and valid bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_kind | input | 2 | Access kind: 00 idle, 01 hit, 10 fill, 11 replace |
| acc_set | input | SET_W (4) | Set index of the access |
| acc_way | input | WAY_W (2) | Way the access refers to |
| probe_set | input | SET_W (4) | Set whose state the outputs describe |
| victim_way | output | WAY_W (2) | Way to fill or replace next in the probed set |
| free_avail | output | 1 | Probed set still has an invalid way |
| probe_valid | output | NUM_WAYS (4) | Valid bits of the probed set, bit i for way i |
| probe_age | output | NUM_WAYS*AGE_W (8) | Ages of the probed set, way i in bits [i*AGE_W +: AGE_W] |

## Verification
The assertions take for granted that the controller behaves like a cache: hits and replacements name a valid way, fills name an invalid way, and replacements are issued only when the set is full. Under that contract the distinct-age invariant and the victim checks must hold at all times. The stimulus follows the contract throughout. It fills empty ways, sometimes out of order to leave gaps. It replaces only the way the tracker itself nominates. It hits only on lines that were filled earlier.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

    // Access kinds reported by the cache controller.
    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_HIT  = 2'b01,
        ACC_FILL = 2'b10,
        ACC_REPL = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/lru_set_next.sv
// Next-state rule for one set: ages and valid bits after one access.
module lru_set_next
    import lru_age_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic                      en,
    input  acc_kind_e                 kind,
    input  logic [WAY_W-1:0]          way,
    input  logic [WAYS-1:0]           vld_q,
    input  logic [WAYS-1:0][AGE_W-1:0] age_q,
    output logic [WAYS-1:0]           vld_d,
    output logic [WAYS-1:0][AGE_W-1:0] age_d
);

    logic [AGE_W-1:0] ref_age;

    always_comb begin
        vld_d   = vld_q;
        age_d   = age_q;
        ref_age = age_q[way];
        if (en) begin
            case (kind)
                ACC_FILL: begin
                    for (int i = 0; i < WAYS; i++) begin
                        if (WAY_W'(i) == way) begin
                            vld_d[i] = 1'b1;
                            age_d[i] = '0;
                        end else if (vld_q[i]) begin
                            age_d[i] = AGE_W'(age_q[i] + 1'b1);
                        end
                    end
                end
                ACC_HIT, ACC_REPL: begin
                    // Only lines younger than the touched one move up.
                    for (int i = 0; i < WAYS; i++) begin
                        if (WAY_W'(i) == way) begin
                            age_d[i] = '0;
                        end else if (vld_q[i] && (age_q[i] < ref_age)) begin
                            age_d[i] = AGE_W'(age_q[i] + 1'b1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lru_victim_sel.sv
// Picks the way to use next: lowest invalid way, else the oldest line.
module lru_victim_sel #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][AGE_W-1:0] age,
    output logic [WAY_W-1:0]           victim,
    output logic                       free
);

    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    logic found;

    always_comb begin
        free   = ~&vld;
        victim = '0;
        found  = 1'b0;
        if (free) begin
            for (int i = 0; i < WAYS; i++) begin
                if (!vld[i] && !found) begin
                    victim = WAY_W'(i);
                    found  = 1'b1;
                end
            end
        end else begin
            for (int i = 0; i < WAYS; i++) begin
                if (age[i] == OLDEST) begin
                    victim = WAY_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker
    import lru_age_pkg::*;
#(
    parameter int  NUM_SETS = 16,
    parameter int  NUM_WAYS = 4,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int AGE_W    = $clog2(NUM_WAYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                acc_kind,
    input  logic [SET_W-1:0]          acc_set,
    input  logic [WAY_W-1:0]          acc_way,
    input  logic [SET_W-1:0]          probe_set,
    output logic [WAY_W-1:0]          victim_way,
    output logic                      free_avail,
    output logic [NUM_WAYS-1:0]       probe_valid,
    output logic [NUM_WAYS*AGE_W-1:0] probe_age
);

    typedef struct packed {
        logic [NUM_WAYS-1:0]            vld;
        logic [NUM_WAYS-1:0][AGE_W-1:0] age;
    } set_st_t;

    typedef struct packed {
        set_st_t [NUM_SETS-1:0] sets;
    } trk_st_t;

    trk_st_t   state_d, state_q;
    acc_kind_e kind;

    logic [NUM_WAYS-1:0]            nxt_vld [NUM_SETS];
    logic [NUM_WAYS-1:0][AGE_W-1:0] nxt_age [NUM_SETS];

    assign kind = acc_kind_e'(acc_kind);

    // One update slice per set; only the addressed one is enabled.
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        lru_set_next #(
            .WAYS  (NUM_WAYS),
            .AGE_W (AGE_W),
            .WAY_W (WAY_W)
        ) u_next (
            .en    (acc_set == SET_W'(s)),
            .kind  (kind),
            .way   (acc_way),
            .vld_q (state_q.sets[s].vld),
            .age_q (state_q.sets[s].age),
            .vld_d (nxt_vld[s]),
            .age_d (nxt_age[s])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int s = 0; s < NUM_SETS; s++) begin
            state_d.sets[s].vld = nxt_vld[s];
            state_d.sets[s].age = nxt_age[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    set_st_t probe_st;
    assign probe_st    = state_q.sets[probe_set];
    assign probe_valid = probe_st.vld;
    assign probe_age   = probe_st.age;

    lru_victim_sel #(
        .WAYS  (NUM_WAYS),
        .AGE_W (AGE_W),
        .WAY_W (WAY_W)
    ) u_pick (
        .vld    (probe_st.vld),
        .age    (probe_st.age),
        .victim (victim_way),
        .free   (free_avail)
    );

    // ------------------------------------------------------------------
    // Checks. Record of the last access, kept for the assertions only.
    acc_kind_e        last_kind_q;
    logic [SET_W-1:0] last_set_q;
    logic [WAY_W-1:0] last_way_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_kind_q <= ACC_NONE;
            last_set_q  <= '0;
            last_way_q  <= '0;
        end else begin
            last_kind_q <= kind;
            last_set_q  <= acc_set;
            last_way_q  <= acc_way;
        end
    end

    set_st_t seen_st;
    assign seen_st = state_q.sets[last_set_q];

    logic [NUM_WAYS-1:0] below_mask;
    assign below_mask = (NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1);

    // R2: a filled way is valid and youngest afterwards.
    p_fill_young_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (last_kind_q == ACC_FILL) |-> (seen_st.vld[last_way_q] && seen_st.age[last_way_q] == '0));

    // R3: a hit leaves the touched line youngest.
    p_hit_young_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_kind_q == ACC_HIT) |-> (seen_st.age[last_way_q] == '0));

    // R7: a replaced line is youngest afterwards.
    p_repl_young_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_kind_q == ACC_REPL) |-> (seen_st.age[last_way_q] == '0));

    // R5: a full set nominates its oldest line.
    p_full_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !free_avail |-> (probe_st.age[victim_way] == AGE_W'(NUM_WAYS - 1)));

    // R6: with a gap, the nominee is invalid and every lower way is valid.
    p_free_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        free_avail |-> (!probe_valid[victim_way] && ((probe_valid & below_mask) == below_mask)));

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk
        // R8, R9: sets not addressed, and idle cycles, leave state untouched.
        p_other_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ((acc_set != SET_W'(s)) || (kind == ACC_NONE)) |=> $stable(state_q.sets[s]));

        for (genvar a = 0; a < NUM_WAYS; a++) begin : g_a
            for (genvar b = a + 1; b < NUM_WAYS; b++) begin : g_b
                // R4: valid lines of one set never share an age.
                p_distinct_age_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    (state_q.sets[s].vld[a] && state_q.sets[s].vld[b])
                        |-> (state_q.sets[s].age[a] != state_q.sets[s].age[b]));
            end
        end
    end

endmodule

// File: tb/lru_age_tracker_bench.sv
module lru_age_tracker_bench;

    localparam int SETS = 16;
    localparam int WAYS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] acc_kind = 2'b00;
    logic [3:0] acc_set = '0;
    logic [1:0] acc_way = '0;
    logic [3:0] probe_set = '0;
    logic [1:0] victim_way;
    logic       free_avail;
    logic [3:0] probe_valid;
    logic [7:0] probe_age;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lru_age_tracker u_lru_age_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_kind    (acc_kind),
        .acc_set     (acc_set),
        .acc_way     (acc_way),
        .probe_set   (probe_set),
        .victim_way  (victim_way),
        .free_avail  (free_avail),
        .probe_valid (probe_valid),
        .probe_age   (probe_age)
    );

    // Fields: kind, set, way, probe, exp valid, exp ages, exp victim, exp free.
    // Ages packed with way i in bits [2i+1:2i].
    localparam int NV = 18;
    localparam logic [26:0] VEC [NV] = '{
        {2'd2, 4'd5, 2'd0, 4'd5, 4'b0001, 8'h00, 2'd1, 1'b1},
        {2'd2, 4'd5, 2'd1, 4'd5, 4'b0011, 8'h01, 2'd2, 1'b1},
        {2'd1, 4'd5, 2'd0, 4'd5, 4'b0011, 8'h04, 2'd2, 1'b1},
        {2'd2, 4'd5, 2'd2, 4'd5, 4'b0111, 8'h09, 2'd3, 1'b1},
        {2'd1, 4'd5, 2'd0, 4'd5, 4'b0111, 8'h18, 2'd3, 1'b1},
        {2'd2, 4'd5, 2'd3, 4'd5, 4'b1111, 8'h2D, 2'd1, 1'b0},
        {2'd1, 4'd5, 2'd0, 4'd5, 4'b1111, 8'h6C, 2'd1, 1'b0},
        {2'd3, 4'd5, 2'd1, 4'd5, 4'b1111, 8'hB1, 2'd2, 1'b0},
        {2'd1, 4'd5, 2'd2, 4'd5, 4'b1111, 8'hC6, 2'd3, 1'b0},
        {2'd1, 4'd5, 2'd3, 4'd5, 4'b1111, 8'h1B, 2'd0, 1'b0},
        {2'd1, 4'd5, 2'd1, 4'd5, 4'b1111, 8'h63, 2'd0, 1'b0},
        {2'd0, 4'd5, 2'd2, 4'd5, 4'b1111, 8'h63, 2'd0, 1'b0},
        {2'd1, 4'd5, 2'd1, 4'd5, 4'b1111, 8'h63, 2'd0, 1'b0},
        {2'd2, 4'd9, 2'd0, 4'd9, 4'b0001, 8'h00, 2'd1, 1'b1},
        {2'd0, 4'd9, 2'd0, 4'd5, 4'b1111, 8'h63, 2'd0, 1'b0},
        {2'd2, 4'd9, 2'd2, 4'd9, 4'b0101, 8'h01, 2'd1, 1'b1},
        {2'd2, 4'd9, 2'd1, 4'd9, 4'b0111, 8'h12, 2'd3, 1'b1},
        {2'd1, 4'd9, 2'd0, 4'd9, 4'b0111, 8'h24, 2'd3, 1'b1}
    };

    function automatic string tag_of(int i);
        case (i)
            0, 1, 3, 13, 16: return "R2 fill";
            5:               return "R5 full set";
            7:               return "R7 replace oldest";
            11:              return "R9 idle";
            14:              return "R8 other set";
            15:              return "R6 lowest gap";
            default:         return "R3 hit";
        endcase
    endfunction

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic access(logic [1:0] k, logic [3:0] s, logic [1:0] w, logic [3:0] p);
        @(negedge clk);
        acc_kind  = k;
        acc_set   = s;
        acc_way   = w;
        probe_set = p;
        @(posedge clk);
        @(negedge clk);
        acc_kind = 2'b00;
        #0.5;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every set starts empty.
        for (int s = 0; s < SETS; s++) begin
            probe_set = 4'(s);
            #0.5;
            check("R1 reset valid", int'(probe_valid), 0);
            check("R1 reset free", int'(free_avail), 1);
            check("R1 reset victim", int'(victim_way), 0);
        end

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            access(v[26:25], v[24:21], v[20:19], v[18:15]);
            check({tag_of(i), " valid"}, int'(probe_valid), int'(v[14:11]));
            check({tag_of(i), " ages"}, int'(probe_age), int'(v[10:3]));
            check({tag_of(i), " victim"}, int'(victim_way), int'(v[2:1]));
            check({tag_of(i), " free"}, int'(free_avail), int'(v[0]));
        end

        // R8: accesses to the top set leave set 5 alone.
        access(2'b10, 4'd15, 2'd0, 4'd5);
        check("R8 top-set fill isolation", int'(probe_age), 8'h63);
        probe_set = 4'd15;
        #0.5;
        check("R8 top-set fill landed", int'(probe_valid), 4'b0001);

        // R4: every set holds distinct ages among its valid lines.
        for (int s = 0; s < SETS; s++) begin
            int clash;
            clash = 0;
            probe_set = 4'(s);
            #0.5;
            for (int a = 0; a < WAYS; a++) begin
                for (int b = a + 1; b < WAYS; b++) begin
                    if (probe_valid[a] && probe_valid[b] &&
                        probe_age[2*a +: 2] == probe_age[2*b +: 2]) clash++;
                end
            end
            check("R4 distinct ages", clash, 0);
        end

        // R1: a second reset clears a full set.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe_set = 4'd5;
        #0.5;
        check("R1 re-reset valid", int'(probe_valid), 0);
        check("R1 re-reset ages", int'(probe_age), 0);
        check("R1 re-reset free", int'(free_avail), 1);

        finish_run();
    end

endmodule